// File: doc/BRIEF.md
# Multi-Hart Machine Timer

This block is a memory-mapped machine timer shared by a group of hardware threads. It keeps one 64-bit time counter, which advances on a timebase tick, and one 64-bit compare register for each hart. For every hart it drives a registered interrupt level that is high while that hart's compare value is at or below the current time.

Software reaches the registers over a simple single-cycle register bus. A size input selects either a 32-bit access to one half of a register or an atomic 64-bit access to a whole register. The time counter can be written as well as read, through either half or as a whole. A time write takes effect at the clock edge that accepts it. Every write to time or to a compare register re-evaluates the interrupt of every hart at that same edge.

Top module: `hart_timer`

## Requirements
- R1: After reset the time counter reads 0, every compare register reads 0xFFFF_FFFF_FFFF_FFFF, and every `irq` bit is 0.
- R2: The time counter increases by exactly one on each clock edge where `tick_en` is 1 and no time write is accepted. It holds its value when `tick_en` is 0.
- R3: A 32-bit write (`bus_wide`=0) to TIME_BASE replaces time bits 31:0, and one to TIME_BASE+4 replaces bits 63:32. The other half keeps its value. An accepted time write overrides a tick in the same cycle, so the written value is stored without the increment.
- R4: A 64-bit access (`bus_wide`=1) at TIME_BASE writes or returns all 64 time bits in one transfer.
- R5: Hart h's compare register occupies the 8-byte slot at CMP_BASE+8*h. A 32-bit access at slot offset 0 covers bits 31:0, and one at offset 4 covers bits 63:32. A write changes only the addressed half. A 32-bit read returns the half in `rd_data[31:0]`, with `rd_data[63:32]`=0.
- R6: A 64-bit access at slot offset 0 of a compare slot writes or returns the whole 64-bit compare value.
- R7: `irq[h]` equals (compare[h] <= time), evaluated on the values stored at each clock edge. A write to time, a write to any compare register, or a tick updates all harts at that same edge.
- R8: A compare access at slot offset 1, 2, 3, 5, 6 or 7, or a 64-bit access at offset 4, is invalid. Its write changes nothing and its read returns 0.
- R9: A read of an address outside the time pair and the compare slots returns 0, and a write to such an address changes no register or interrupt.
- R10: Every read request gets `rd_valid`=1 exactly one cycle later, carrying the value the register held in the request cycle. `rd_valid` is 0 in every other cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | Timebase tick from a prescaler; time advances when high |
| bus_valid | input | 1 | Bus request in this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_wide | input | 1 | 1 = 64-bit access, 0 = 32-bit access |
| bus_addr | input | AW | Byte address |
| bus_wdata | input | 64 | Write data (bits 31:0 used for 32-bit accesses) |
| rd_valid | output | 1 | Read response valid |
| rd_data | output | 64 | Read response data |
| irq | output | NUM_HARTS | Per-hart timer interrupt level |

## Verification
A wrong merge of a half write shows up on the next read of the other half as a changed value. It also shows up on `irq` at the same edge when the compare relation flips. A stale or wrong interrupt term would leave some `irq` bit disagreeing with compare <= time in the first cycle after a time write. Because of that, the bench checks every `irq` bit right after each write and across a tick sequence that crosses a compare value. A decode error is exposed within one read by a value that should be zero, or by a register that should have been left alone and was changed.

// File: rtl/hart_timer_pkg.sv
package hart_timer_pkg;

  typedef enum logic [1:0] {
    ACC_NONE = 2'd0,
    ACC_LO   = 2'd1,
    ACC_HI   = 2'd2,
    ACC_FULL = 2'd3
  } acc_kind_e;

  typedef struct packed {
    logic      hit_time;
    logic      hit_cmp;
    acc_kind_e kind;
  } dec_t;

  // Merge bus data into a stored 64-bit value according to access kind
  function automatic logic [63:0] merge_word(input logic [63:0] cur,
                                             input logic [63:0] wd,
                                             input acc_kind_e   k);
    case (k)
      ACC_LO:   return {cur[63:32], wd[31:0]};
      ACC_HI:   return {wd[31:0], cur[31:0]};
      ACC_FULL: return wd;
      default:  return cur;
    endcase
  endfunction

  // Pick the slice of a stored value that a read returns
  function automatic logic [63:0] read_slice(input logic [63:0] val,
                                             input acc_kind_e   k);
    case (k)
      ACC_LO:   return {32'd0, val[31:0]};
      ACC_HI:   return {32'd0, val[63:32]};
      ACC_FULL: return val;
      default:  return 64'd0;
    endcase
  endfunction

endpackage

// File: rtl/htm_decode.sv
module htm_decode
  import hart_timer_pkg::*;
#(
  parameter int unsigned     AW        = 16,
  parameter int unsigned     NUM_HARTS = 4,
  parameter int unsigned     IDX_W     = 2,
  parameter logic [AW-1:0]   TIME_BASE = 'h7FF8,
  parameter logic [AW-1:0]   CMP_BASE  = 'h0000,
  parameter bit              WIDE_EN   = 1'b1
) (
  input  logic [AW-1:0]    addr,
  input  logic             wide,
  output dec_t             dec,
  output logic [IDX_W-1:0] idx
);

  localparam logic [AW:0] CMP_LO  = (AW+1)'(CMP_BASE);
  localparam logic [AW:0] CMP_END = (AW+1)'(CMP_BASE) + (AW+1)'(8 * NUM_HARTS);

  logic      wide_ok;
  logic      in_cmp;
  logic      in_time;
  acc_kind_e kind_w;

  generate
    if (WIDE_EN) begin : g_wide
      assign wide_ok = 1'b1;
    end else begin : g_narrow
      assign wide_ok = 1'b0;
    end
  endgenerate

  always_comb begin
    if (wide) begin
      kind_w = (wide_ok && addr[2:0] == 3'd0) ? ACC_FULL : ACC_NONE;
    end else begin
      case (addr[2:0])
        3'd0:    kind_w = ACC_LO;
        3'd4:    kind_w = ACC_HI;
        default: kind_w = ACC_NONE;
      endcase
    end
  end

  assign in_cmp  = ({1'b0, addr} >= CMP_LO) && ({1'b0, addr} < CMP_END);
  assign in_time = (addr[AW-1:3] == TIME_BASE[AW-1:3]);

  always_comb begin
    dec.hit_time = in_time && (kind_w != ACC_NONE);
    dec.hit_cmp  = in_cmp && !in_time && (kind_w != ACC_NONE);
    dec.kind     = (in_time || in_cmp) ? kind_w : ACC_NONE;
    idx          = IDX_W'((addr - CMP_BASE) >> 3);
  end

endmodule

// File: rtl/htm_time_counter.sv
module htm_time_counter
  import hart_timer_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        tick_en,
  input  logic        wr_en,
  input  acc_kind_e   kind,
  input  logic [63:0] wdata,
  output logic [63:0] time_q,
  output logic [63:0] time_d
);

  always_comb begin
    time_d = time_q;
    if (wr_en) begin
      time_d = merge_word(time_q, wdata, kind);
    end else if (tick_en) begin
      time_d = time_q + 64'd1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      time_q <= 64'd0;
    end else begin
      time_q <= time_d;
    end
  end

endmodule

// File: rtl/htm_cmp_bank.sv
module htm_cmp_bank
  import hart_timer_pkg::*;
#(
  parameter int unsigned NUM_HARTS = 4,
  parameter int unsigned IDX_W     = 2
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           wr_en,
  input  logic [IDX_W-1:0]               wr_idx,
  input  acc_kind_e                      kind,
  input  logic [63:0]                    wdata,
  input  logic [63:0]                    time_d,
  output logic [NUM_HARTS-1:0][63:0]     cmp_q,
  output logic [NUM_HARTS-1:0]           irq
);

  for (genvar h = 0; h < NUM_HARTS; h++) begin : g_slot
    logic        sel;
    logic [63:0] cmp_d;

    assign sel   = wr_en && (wr_idx == IDX_W'(h));
    assign cmp_d = sel ? merge_word(cmp_q[h], wdata, kind) : cmp_q[h];

    always_ff @(posedge clk) begin
      if (rst) begin
        cmp_q[h] <= '1;
        irq[h]   <= 1'b0;
      end else begin
        cmp_q[h] <= cmp_d;
        irq[h]   <= (cmp_d <= time_d);
      end
    end
  end

endmodule

// File: rtl/htm_read_mux.sv
module htm_read_mux
  import hart_timer_pkg::*;
#(
  parameter int unsigned NUM_HARTS = 4,
  parameter int unsigned IDX_W     = 2
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       rd_req,
  input  dec_t                       dec,
  input  logic [IDX_W-1:0]           idx,
  input  logic [63:0]                time_q,
  input  logic [NUM_HARTS-1:0][63:0] cmp_q,
  output logic                       rd_valid,
  output logic [63:0]                rd_data
);

  logic [63:0] src;
  logic [63:0] nxt;

  always_comb begin
    src = 64'd0;
    if (dec.hit_time) begin
      src = time_q;
    end else if (dec.hit_cmp) begin
      for (int h = 0; h < NUM_HARTS; h++) begin
        if (idx == IDX_W'(h)) src = cmp_q[h];
      end
    end
    nxt = (dec.hit_time || dec.hit_cmp) ? read_slice(src, dec.kind) : 64'd0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid <= 1'b0;
      rd_data  <= 64'd0;
    end else begin
      rd_valid <= rd_req;
      rd_data  <= rd_req ? nxt : 64'd0;
    end
  end

endmodule

// File: rtl/hart_timer.sv
module hart_timer
  import hart_timer_pkg::*;
#(
  parameter int unsigned   AW        = 16,
  parameter int unsigned   NUM_HARTS = 4,
  parameter logic [AW-1:0] TIME_BASE = 'h7FF8,
  parameter logic [AW-1:0] CMP_BASE  = 'h0000,
  parameter bit            WIDE_EN   = 1'b1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 tick_en,
  input  logic                 bus_valid,
  input  logic                 bus_we,
  input  logic                 bus_wide,
  input  logic [AW-1:0]        bus_addr,
  input  logic [63:0]          bus_wdata,
  output logic                 rd_valid,
  output logic [63:0]          rd_data,
  output logic [NUM_HARTS-1:0] irq
);

  localparam int unsigned IDX_W = (NUM_HARTS > 1) ? $clog2(NUM_HARTS) : 1;

  dec_t                       dec;
  logic [IDX_W-1:0]           idx;
  logic [63:0]                time_now;
  logic [63:0]                time_nxt;
  logic [NUM_HARTS-1:0][63:0] cmp_q;
  logic                       wr_time;
  logic                       wr_cmp;
  logic                       rd_req;

  htm_decode #(
    .AW(AW), .NUM_HARTS(NUM_HARTS), .IDX_W(IDX_W),
    .TIME_BASE(TIME_BASE), .CMP_BASE(CMP_BASE), .WIDE_EN(WIDE_EN)
  ) u_dec (
    .addr (bus_addr),
    .wide (bus_wide),
    .dec  (dec),
    .idx  (idx)
  );

  assign wr_time = bus_valid && bus_we && dec.hit_time;
  assign wr_cmp  = bus_valid && bus_we && dec.hit_cmp;
  assign rd_req  = bus_valid && !bus_we;

  htm_time_counter u_time (
    .clk     (clk),
    .rst     (rst),
    .tick_en (tick_en),
    .wr_en   (wr_time),
    .kind    (dec.kind),
    .wdata   (bus_wdata),
    .time_q  (time_now),
    .time_d  (time_nxt)
  );

  htm_cmp_bank #(.NUM_HARTS(NUM_HARTS), .IDX_W(IDX_W)) u_cmp (
    .clk    (clk),
    .rst    (rst),
    .wr_en  (wr_cmp),
    .wr_idx (idx),
    .kind   (dec.kind),
    .wdata  (bus_wdata),
    .time_d (time_nxt),
    .cmp_q  (cmp_q),
    .irq    (irq)
  );

  htm_read_mux #(.NUM_HARTS(NUM_HARTS), .IDX_W(IDX_W)) u_rd (
    .clk      (clk),
    .rst      (rst),
    .rd_req   (rd_req),
    .dec      (dec),
    .idx      (idx),
    .time_q   (time_now),
    .cmp_q    (cmp_q),
    .rd_valid (rd_valid),
    .rd_data  (rd_data)
  );

endmodule

// File: rtl/hart_timer_chk.sv
module hart_timer_chk #(
  parameter int unsigned NUM_HARTS = 4
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 tick_en,
  input logic                 bus_valid,
  input logic                 bus_we,
  input logic                 rd_valid,
  input logic [NUM_HARTS-1:0] irq,
  input logic [63:0]          time_now
);

  AST_IRQ_CLEAR_AFTER_RESET: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (irq == '0)); // R1

  AST_TIME_TICK: assert property (@(posedge clk) disable iff (rst)
    (tick_en && !bus_valid) |=> (time_now == $past(time_now) + 64'd1)); // R2

  AST_TIME_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!tick_en && !bus_valid) |=> $stable(time_now)); // R2

  AST_IRQ_STABLE_IDLE: assert property (@(posedge clk) disable iff (rst)
    (!tick_en && !bus_valid) |=> $stable(irq)); // R7

  AST_RSP_AFTER_READ: assert property (@(posedge clk) disable iff (rst)
    (bus_valid && !bus_we) |=> rd_valid); // R10

  AST_RSP_ONLY_ON_READ: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> $past(bus_valid && !bus_we)); // R10

endmodule

bind hart_timer hart_timer_chk #(.NUM_HARTS(NUM_HARTS)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .tick_en   (tick_en),
  .bus_valid (bus_valid),
  .bus_we    (bus_we),
  .rd_valid  (rd_valid),
  .irq       (irq),
  .time_now  (time_now)
);

// File: tb/hart_timer_test.sv
module hart_timer_test;

  localparam int unsigned N = 4;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          tick_en = 1'b0;
  logic          bus_valid = 1'b0;
  logic          bus_we = 1'b0;
  logic          bus_wide = 1'b0;
  logic [15:0]   bus_addr = '0;
  logic [63:0]   bus_wdata = '0;
  logic          rd_valid;
  logic [63:0]   rd_data;
  logic [N-1:0]  irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [63:0] exp_q[$];
  string       tag_q[$];

  localparam logic [63:0] ONES = 64'hFFFF_FFFF_FFFF_FFFF;

  always #4 clk = ~clk; // 125 MHz

  hart_timer #(.AW(16), .NUM_HARTS(N)) uut (
    .clk(clk), .rst(rst), .tick_en(tick_en),
    .bus_valid(bus_valid), .bus_we(bus_we), .bus_wide(bus_wide),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .rd_valid(rd_valid), .rd_data(rd_data), .irq(irq)
  );

  task automatic check(input bit ok, input string tag, input logic [63:0] act,
                       input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [63:0] d,
                    input logic w, input logic tk);
    bus_valid = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    bus_wide = w; tick_en = tk;
    @(negedge clk);
    bus_valid = 1'b0; bus_we = 1'b0; tick_en = 1'b0;
  endtask

  task automatic rd(input logic [15:0] a, input logic w,
                    input logic [63:0] e, input string tag);
    exp_q.push_back(e);
    tag_q.push_back(tag);
    bus_valid = 1'b1; bus_we = 1'b0; bus_addr = a; bus_wide = w;
    @(negedge clk);
    bus_valid = 1'b0;
  endtask

  task automatic irq_is(input logic [N-1:0] e, input string tag);
    check(irq == e, tag, 64'(irq), 64'(e));
  endtask

  // Monitor: pops one expected item for every response
  always @(negedge clk) begin
    if (!rst && rd_valid) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R10 response without request", rd_data, 64'd0);
      end else begin
        logic [63:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(rd_data == e, t, rd_data, e);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=%h expected=%h", 64'd0, 64'd1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    irq_is('0, "R1 irq after reset");
    rd(16'h7FF8, 1'b1, 64'd0, "R1 time after reset");
    rd(16'h0010, 1'b1, ONES, "R1 cmp2 after reset");

    // R2 ticking
    tick_en = 1'b1;
    repeat (10) @(negedge clk);
    tick_en = 1'b0;
    rd(16'h7FF8, 1'b1, 64'd10, "R2 time after 10 ticks");
    check(rd_valid == 1'b1, "R10 valid after read", 64'(rd_valid), 64'd1);
    @(negedge clk);
    check(rd_valid == 1'b0, "R10 valid idle", 64'(rd_valid), 64'd0);

    // R3 split time writes
    wr(16'h7FF8, 64'hFFFF_FFF0, 1'b0, 1'b0);
    rd(16'h7FF8, 1'b0, 64'hFFFF_FFF0, "R3 time lo after lo write");
    rd(16'h7FFC, 1'b0, 64'd0, "R3 time hi kept");
    wr(16'h7FFC, 64'h12, 1'b0, 1'b0);
    rd(16'h7FF8, 1'b1, 64'h12_FFFF_FFF0, "R3 time after hi write");
    wr(16'h7FF8, 64'h5, 1'b0, 1'b1);
    rd(16'h7FF8, 1'b1, 64'h12_0000_0005, "R3 write beats tick");

    // R4 wide time
    wr(16'h7FF8, 64'h1_0000_0000, 1'b1, 1'b0);
    rd(16'h7FF8, 1'b1, 64'h1_0000_0000, "R4 wide time");
    rd(16'h7FFC, 1'b0, 64'h1, "R4 time hi after wide write");

    // R5 split compare
    wr(16'h0008, 64'h100, 1'b0, 1'b0);
    rd(16'h0008, 1'b1, 64'hFFFF_FFFF_0000_0100, "R5 cmp1 lo write keeps hi");
    wr(16'h000C, 64'h0, 1'b0, 1'b0);
    irq_is(4'b0010, "R7 irq after cmp1 write");
    rd(16'h0008, 1'b0, 64'h100, "R5 cmp1 lo read");
    rd(16'h000C, 1'b0, 64'h0, "R5 cmp1 hi read");

    // R6 wide compare
    wr(16'h0018, 64'h2_0000_0000, 1'b1, 1'b0);
    rd(16'h0018, 1'b1, 64'h2_0000_0000, "R6 cmp3 wide");
    irq_is(4'b0010, "R7 irq cmp3 above time");

    // R7 re-evaluation on time writes
    wr(16'h7FF8, 64'h2_0000_0000, 1'b1, 1'b0);
    irq_is(4'b1010, "R7 irq after time raise");
    wr(16'h7FFC, 64'h0, 1'b0, 1'b0);
    irq_is(4'b0000, "R7 irq after time lowered");
    wr(16'h0000, 64'h0, 1'b1, 1'b0);
    irq_is(4'b0001, "R7 irq cmp0 zero");

    // R8 invalid compare offsets
    wr(16'h0011, 64'h55, 1'b0, 1'b0);
    wr(16'h0014, 64'h0, 1'b1, 1'b0);
    irq_is(4'b0001, "R8 irq unchanged");
    rd(16'h0010, 1'b1, ONES, "R8 cmp2 untouched");
    rd(16'h0011, 1'b0, 64'd0, "R8 odd offset read");
    rd(16'h0014, 1'b1, 64'd0, "R8 wide at offset 4 read");

    // R9 unmapped
    wr(16'h0020, 64'h0, 1'b1, 1'b0);
    wr(16'h4000, 64'h0, 1'b0, 1'b0);
    irq_is(4'b0001, "R9 irq unchanged");
    rd(16'h0020, 1'b1, 64'd0, "R9 unmapped read past slots");
    rd(16'h4000, 1'b0, 64'd0, "R9 unmapped read");
    rd(16'h7FF8, 1'b1, 64'd0, "R9 time unchanged");

    // R7 with ticks crossing a compare value
    wr(16'h0010, 64'h5, 1'b1, 1'b0);
    irq_is(4'b0001, "R7 cmp2 above time");
    tick_en = 1'b1;
    repeat (4) @(negedge clk);
    tick_en = 1'b0;
    irq_is(4'b0001, "R7 before crossing");
    tick_en = 1'b1;
    @(negedge clk);
    tick_en = 1'b0;
    irq_is(4'b0101, "R7 at crossing");
    rd(16'h7FF8, 1'b1, 64'd5, "R2 time after 5 ticks");

    repeat (3) @(negedge clk);
    check(exp_q.size() == 0, "R10 all reads answered", 64'(exp_q.size()), 64'd0);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule